// File: doc/BRIEF.md
# Burst configuration command sequencer

This block sits beside a host write port and watches every write cycle, each of which carries an address and a data byte. It looks for a three-write command. Two unlock writes come first. The third write carries a confirm byte. When the command completes, the sequencer copies a configuration code from the upper address bits of the third write into a burst configuration register. The data bus only identifies the command; it never supplies the value.

The register contents are decoded onto dedicated outputs: read mode, RDY timing, active clock edge, burst kind and wait-state code. A synchronous-mode flag and a one-cycle update strobe are also provided. While an embedded program, erase or lock operation is running, a load attempt is refused. Reset returns every field to its default value.

Top module: `burst_cfg_seq`

## Requirements
- R1: After reset the outputs show the default configuration. The defaults are: asynchronous mode (cfg_async=1), RDY with data (rdy_with_data=1), rising edge (rise_edge=1), continuous burst (burst_mode=00) and wait code 101. sync_active and cfg_loaded are 0.
- R2: A load needs three writes in order. The first is address 555h with data AAh. The second is address 2AAh with data 55h. The third is address 555h with data C0h. When the third write is sampled on a clock edge, the register and all decoded outputs take the new value at that same edge.
- R3: The latched code is wr_addr[19:12], mapped as follows. Bit 19 is cfg_async (1 = asynchronous). Bit 18 is rdy_with_data (1 = with data, 0 = one clock early). Bit 17 is rise_edge (1 = rising, 0 = falling). Bits 16:15 are burst_mode (00 continuous, 01 8-word wrap, 10 16-word wrap, 11 32-word wrap). Bits 14:12 are wait_code.
- R4: sync_active is 1 exactly when the latched bit 19 is 0.
- R5: Each write is matched against wr_addr[11:0] and wr_data only. Address bits 19:12 of the two unlock writes have no effect.
- R6: A write that does not match the expected step ends the sequence. A later confirm write then loads nothing.
- R7: If a write breaks the sequence but is itself a valid first unlock write (555h/AAh), the sequence resumes as though that write were the first step.
- R8: A confirm write sampled while op_busy=1 is refused. No strobe is raised, the register is unchanged, and the sequence returns to its start.
- R9: Clock cycles with wr_en=0 neither advance nor reset the sequence.
- R10: cfg_loaded is high for exactly one cycle after each accepted load. This includes a load that writes the value already held. cfg_loaded is low at all other times.
- R11: Asserting reset in the middle of a sequence, or after a load, restores the defaults and discards any partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; write cycles are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | A host write is present in this cycle |
| wr_addr | input | 20 | Write address; low 12 bits are matched, upper 8 bits supply the code |
| wr_data | input | 8 | Write data byte |
| op_busy | input | 1 | An embedded program, erase or lock operation is running |
| cfg_async | output | 1 | 1 = asynchronous read mode |
| rdy_with_data | output | 1 | 1 = RDY with data, 0 = RDY one clock early |
| rise_edge | output | 1 | 1 = rising active edge, 0 = falling |
| burst_mode | output | 2 | Burst kind code |
| wait_code | output | 3 | Wait-state code |
| sync_active | output | 1 | Synchronous read mode is in effect |
| cfg_loaded | output | 1 | One-cycle strobe on each accepted load |

## Verification
The assertions assume that wr_addr, wr_data and op_busy are stable across the rising edge at which wr_en is sampled. They also assume that reset begins low at time zero. The stimulus satisfies both assumptions. It drives every input on the falling edge, holds each write for exactly one cycle with op_busy only during that cycle, and keeps wr_en low while reset is asserted. Because each strobe assertion compares the latched code with the previous cycle's address, the bench never issues a write during the cycle in which reset is released.

// File: rtl/burst_cfg_pkg.sv
package burst_cfg_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_GOT1 = 2'd1,
      SEQ_GOT2 = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      BURST_CONT = 2'b00,
      BURST_W8   = 2'b01,
      BURST_W16  = 2'b10,
      BURST_W32  = 2'b11
   } burst_kind_e;

   // Field order follows the address bits that feed it (MSB = bit 19).
   typedef struct packed {
      logic        async_mode;
      logic        rdy_with_data;
      logic        rise_edge;
      burst_kind_e burst;
      logic [2:0]  wait_code;
   } cfg_word_t;

   localparam int CFG_W = $bits(cfg_word_t);

   localparam cfg_word_t CFG_DEFAULT = '{
      async_mode:    1'b1,
      rdy_with_data: 1'b1,
      rise_edge:     1'b1,
      burst:         BURST_CONT,
      wait_code:     3'b101
   };

endpackage

// File: rtl/burst_cmd_recognizer.sv
module burst_cmd_recognizer
   import burst_cfg_pkg::*;
#(
   parameter int                 DATA_W            = 8,
   parameter int                 MATCH_W           = 12,
   parameter logic [MATCH_W-1:0] STEP1_ADDR        = 12'h555,
   parameter logic [DATA_W-1:0]  STEP1_DATA        = 8'hAA,
   parameter logic [MATCH_W-1:0] STEP2_ADDR        = 12'h2AA,
   parameter logic [DATA_W-1:0]  STEP2_DATA        = 8'h55,
   parameter logic [MATCH_W-1:0] CONFIRM_ADDR      = 12'h555,
   parameter logic [DATA_W-1:0]  CONFIRM_DATA      = 8'hC0,
   parameter bit                 RESTART_ON_UNLOCK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [MATCH_W-1:0] addr_lo_i,
   input  logic [DATA_W-1:0]  data_i,
   input  logic               busy_i,
   output logic               load_o
);

   generate
      if (MATCH_W < 1) begin : g_bad_match
         $error("burst_cmd_recognizer: MATCH_W must be positive");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("burst_cmd_recognizer: DATA_W must be positive");
      end
   endgenerate

   seq_state_e state_q, state_d, brk_state;
   logic       hit1, hit2, hit3;

   assign hit1 = (addr_lo_i == STEP1_ADDR)   && (data_i == STEP1_DATA);
   assign hit2 = (addr_lo_i == STEP2_ADDR)   && (data_i == STEP2_DATA);
   assign hit3 = (addr_lo_i == CONFIRM_ADDR) && (data_i == CONFIRM_DATA);

   // Where a sequence-breaking write sends the recogniser.
   generate
      if (RESTART_ON_UNLOCK) begin : g_restart
         assign brk_state = hit1 ? SEQ_GOT1 : SEQ_IDLE;
      end else begin : g_plain
         assign brk_state = SEQ_IDLE;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      if (wr_en_i) begin
         unique case (state_q)
            SEQ_IDLE: state_d = hit1 ? SEQ_GOT1 : SEQ_IDLE;
            SEQ_GOT1: state_d = hit2 ? SEQ_GOT2 : brk_state;
            SEQ_GOT2: begin
               if (hit3) begin
                  state_d = SEQ_IDLE;
                  load_o  = !busy_i;
               end else begin
                  state_d = brk_state;
               end
            end
            default:  state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   // R9: no write, no movement of the sequence
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(state_q));

   // R2: reaching the final step needs a second unlock write just before
   assert_step2_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_GOT2 && $past(state_q) != SEQ_GOT2)
         |-> ($past(wr_en_i) && $past(data_i) == STEP2_DATA && $past(state_q) == SEQ_GOT1));

   // R8: a refused confirm leaves the recogniser at its start
   assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && busy_i && state_q == SEQ_GOT2 && hit3) |=> state_q == SEQ_IDLE);

endmodule

// File: rtl/burst_cfg_register.sv
module burst_cfg_register
   import burst_cfg_pkg::*;
#(
   parameter int        CODE_W    = CFG_W,
   parameter cfg_word_t RESET_CFG = CFG_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   output cfg_word_t         cfg_o,
   output logic              loaded_o
);

   generate
      if (CODE_W != CFG_W) begin : g_bad_width
         $error("burst_cfg_register: CODE_W must equal the configuration word width");
      end
   endgenerate

   cfg_word_t cfg_q;
   logic      loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= RESET_CFG;
         loaded_q <= 1'b0;
      end else begin
         loaded_q <= load_i;
         if (load_i) cfg_q <= cfg_word_t'(code_i);
      end
   end

   assign cfg_o    = cfg_q;
   assign loaded_o = loaded_q;

   // R2/R8: contents change only on an accepted load
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(cfg_q));

   // R10: strobe marks exactly the cycle after a load
   assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (loaded_q && cfg_q == $past(code_i)));

endmodule

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
   import burst_cfg_pkg::*;
#(
   parameter int WAIT_W  = 3,
   parameter int BURST_W = 2
) (
   input  cfg_word_t          cfg_i,
   output logic               async_o,
   output logic               sync_o,
   output logic               rdy_o,
   output logic               rise_o,
   output logic [BURST_W-1:0] burst_o,
   output logic [WAIT_W-1:0]  wait_o
);

   generate
      if (WAIT_W != $bits(cfg_i.wait_code)) begin : g_bad_wait
         $error("burst_cfg_decode: WAIT_W does not match the configuration word");
      end
      if (BURST_W != $bits(cfg_i.burst)) begin : g_bad_burst
         $error("burst_cfg_decode: BURST_W does not match the configuration word");
      end
   endgenerate

   assign async_o = cfg_i.async_mode;
   assign sync_o  = ~cfg_i.async_mode;
   assign rdy_o   = cfg_i.rdy_with_data;
   assign rise_o  = cfg_i.rise_edge;
   assign burst_o = cfg_i.burst;
   assign wait_o  = cfg_i.wait_code;

endmodule

// File: rtl/burst_cfg_seq.sv
module burst_cfg_seq
   import burst_cfg_pkg::*;
#(
   parameter int ADDR_W            = 20,
   parameter int DATA_W            = 8,
   parameter int MATCH_W           = 12,
   parameter int CODE_LSB          = 12,
   parameter bit RESTART_ON_UNLOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              op_busy,
   output logic              cfg_async,
   output logic              rdy_with_data,
   output logic              rise_edge,
   output logic [1:0]        burst_mode,
   output logic [2:0]        wait_code,
   output logic              sync_active,
   output logic              cfg_loaded
);

   localparam int                 CODE_MSB   = CODE_LSB + CFG_W - 1;
   localparam logic [DATA_W-1:0]  CONF_BYTE  = DATA_W'(8'hC0);

   generate
      if (CODE_MSB != ADDR_W - 1) begin : g_bad_addr
         $error("burst_cfg_seq: code field must occupy the top address bits");
      end
      if (CODE_LSB < MATCH_W) begin : g_bad_overlap
         $error("burst_cfg_seq: code field overlaps the matched address bits");
      end
      if (DATA_W != 8) begin : g_bad_byte
         $error("burst_cfg_seq: command bytes are eight bits wide");
      end
   endgenerate

   logic      load;
   cfg_word_t cfg;

   burst_cmd_recognizer #(
      .DATA_W            (DATA_W),
      .MATCH_W           (MATCH_W),
      .STEP1_ADDR        (MATCH_W'(12'h555)),
      .STEP1_DATA        (DATA_W'(8'hAA)),
      .STEP2_ADDR        (MATCH_W'(12'h2AA)),
      .STEP2_DATA        (DATA_W'(8'h55)),
      .CONFIRM_ADDR      (MATCH_W'(12'h555)),
      .CONFIRM_DATA      (CONF_BYTE),
      .RESTART_ON_UNLOCK (RESTART_ON_UNLOCK)
   ) u_recog (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .addr_lo_i (wr_addr[MATCH_W-1:0]),
      .data_i    (wr_data),
      .busy_i    (op_busy),
      .load_o    (load)
   );

   burst_cfg_register #(
      .CODE_W    (CFG_W),
      .RESET_CFG (CFG_DEFAULT)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .code_i   (wr_addr[CODE_MSB:CODE_LSB]),
      .cfg_o    (cfg),
      .loaded_o (cfg_loaded)
   );

   burst_cfg_decode #(
      .WAIT_W  (3),
      .BURST_W (2)
   ) u_dec (
      .cfg_i   (cfg),
      .async_o (cfg_async),
      .sync_o  (sync_active),
      .rdy_o   (rdy_with_data),
      .rise_o  (rise_edge),
      .burst_o (burst_mode),
      .wait_o  (wait_code)
   );

   // R3: outputs after a strobe mirror the upper address bits of the confirm write
   assert_code_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_loaded |-> ({cfg_async, rdy_with_data, rise_edge, burst_mode, wait_code}
                      == $past(wr_addr[CODE_MSB:CODE_LSB])));

   // R8: an accepted load never coincides with a busy embedded operation
   assert_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_loaded |-> ($past(wr_en) && !$past(op_busy) && $past(wr_data) == CONF_BYTE));

   // R10: the strobe never lasts two cycles
   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_loaded |=> !cfg_loaded);

   // R4: synchronous flag is the complement of the read-mode field
   assert_sync_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sync_active != cfg_async);

endmodule

// File: tb/burst_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module burst_cfg_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [19:0] wr_addr;
   logic [7:0]  wr_data;
   logic        op_busy;
   logic        cfg_async, rdy_with_data, rise_edge, sync_active, cfg_loaded;
   logic [1:0]  burst_mode;
   logic [2:0]  wait_code;

   always #4 clk = ~clk;

   burst_cfg_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .op_busy(op_busy), .cfg_async(cfg_async),
      .rdy_with_data(rdy_with_data), .rise_edge(rise_edge),
      .burst_mode(burst_mode), .wait_code(wait_code),
      .sync_active(sync_active), .cfg_loaded(cfg_loaded)
   );

   typedef struct {
      bit         load;
      logic [7:0] code;
      string      tag;
   } exp_t;

   exp_t       sb_q[$];
   exp_t       mon_e;
   bit         mon_w;
   logic [7:0] model_cfg = 8'hE5;
   int         total = 0;
   int         bad = 0;
   bit         done = 0;

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] port_code();
      return {cfg_async, rdy_with_data, rise_edge, burst_mode, wait_code};
   endfunction

   // Driver: one write cycle, expectation pushed to the scoreboard.
   task automatic wr(logic [19:0] a, logic [7:0] d, bit busy, bit ld, string tag, int gap = 0);
      exp_t e;
      if (ld) model_cfg = a[19:12];
      e.load = ld;
      e.code = model_cfg;
      e.tag  = tag;
      sb_q.push_back(e);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; op_busy = busy;
      @(negedge clk);
      wr_en = 1'b0; op_busy = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic full_load(logic [7:0] code, string tag, int gap = 0);
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, tag, gap);
      wr(20'h002AA, 8'h55, 1'b0, 1'b0, tag, gap);
      wr({code, 12'h555}, 8'hC0, 1'b0, 1'b1, tag, gap);
   endtask

   task automatic check_defaults(string tag);
      check(tag, "cfg_word", 32'(port_code()), 32'hE5);
      check(tag, "sync_active", 32'(sync_active), 32'h0);
      check(tag, "cfg_loaded", 32'(cfg_loaded), 32'h0);
   endtask

   // Monitor: pops one expectation per sampled write, 2 ns after the edge.
   always @(posedge clk) begin
      mon_w = wr_en && rst_n;
      #2;
      if (mon_w) begin
         if (sb_q.size() == 0) begin
            check("SB", "queue_empty", 32'h1, 32'h0);
         end else begin
            mon_e = sb_q.pop_front();
            check({mon_e.tag, "/R10"}, "cfg_loaded", 32'(cfg_loaded), 32'(mon_e.load));
            check({mon_e.tag, "/R3"}, "cfg_word", 32'(port_code()), 32'(mon_e.code));
            check({mon_e.tag, "/R4"}, "sync_active", 32'(sync_active), 32'(!mon_e.code[7]));
         end
      end else if (rst_n && !done) begin
         check("R10_idle", "cfg_loaded", 32'(cfg_loaded), 32'h0);
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; op_busy = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_defaults("R1");

      // R2 R3 R4: several codes covering every burst kind and both field polarities
      full_load(8'h00, "R2_code00");
      full_load(8'h8B, "R3_code8B");
      full_load(8'h5E, "R3_code5E");
      full_load(8'h36, "R4_code36");

      // R5: upper address bits on unlock writes are ignored
      wr(20'h7F555, 8'hAA, 1'b0, 1'b0, "R5");
      wr(20'hA12AA, 8'h55, 1'b0, 1'b0, "R5");
      wr(20'h4D555, 8'hC0, 1'b0, 1'b1, "R5");

      // R6: wrong data on step two, then a confirm loads nothing
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R6");
      wr(20'h002AA, 8'h00, 1'b0, 1'b0, "R6");
      wr(20'hFF555, 8'hC0, 1'b0, 1'b0, "R6");
      // R6: wrong address on the confirm step, then a good confirm loads nothing
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R6");
      wr(20'h002AA, 8'h55, 1'b0, 1'b0, "R6");
      wr(20'h11554, 8'hC0, 1'b0, 1'b0, "R6");
      wr(20'h11555, 8'hC0, 1'b0, 1'b0, "R6");

      // R7: repeated first unlock restarts at step two
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R7");
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R7");
      wr(20'h002AA, 8'h55, 1'b0, 1'b0, "R7");
      wr(20'h63555, 8'hC0, 1'b0, 1'b1, "R7");
      // R7: first unlock in place of the confirm
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R7");
      wr(20'h002AA, 8'h55, 1'b0, 1'b0, "R7");
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R7");
      wr(20'h002AA, 8'h55, 1'b0, 1'b0, "R7");
      wr(20'h9C555, 8'hC0, 1'b0, 1'b1, "R7");

      // R8: confirm during busy is refused and the sequence restarts
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R8");
      wr(20'h002AA, 8'h55, 1'b0, 1'b0, "R8");
      wr(20'h00555, 8'hC0, 1'b1, 1'b0, "R8");
      wr(20'h00555, 8'hC0, 1'b0, 1'b0, "R8");

      // R9: idle gaps between the writes do not disturb the sequence
      full_load(8'hC7, "R9", 5);

      // R10: loading the same value again still pulses
      full_load(8'hC7, "R10");

      // R11: reset with a partial sequence pending
      wr(20'h00555, 8'hAA, 1'b0, 1'b0, "R11");
      @(negedge clk);
      rst_n = 1'b0;
      model_cfg = 8'hE5;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_defaults("R11");
      wr(20'h002AA, 8'h55, 1'b0, 1'b0, "R11");
      wr(20'h00555, 8'hC0, 1'b0, 1'b0, "R11");

      repeat (3) @(negedge clk);
      check("SB", "leftover", 32'(sb_q.size()), 32'h0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule